// File: doc/BRIEF.md
# Silence-Delimited Serial Frame Splitter

This block sits behind a byte-level serial receiver and cuts the incoming character stream into frames using line silence alone; no delimiter characters exist. A timer counts clock cycles since the last character. When the silence reaches three and a half character times, the open frame is closed. The next character to arrive is taken as the station address of a new frame. The character time is derived at run time from a cycles-per-bit parameter and the parity and stop-bit settings.

Each received byte is passed on, tagged as the first byte (the address) or the final byte of its frame. This stream feeds a separate check engine. When a frame closes, the block decides whether the frame may be acted upon. The frame must have at least four bytes and no character may carry a parity or framing error. Its address must be the local station address or the broadcast address 0. For such a frame, the last two bytes are offered to the check engine. A frame-valid pulse follows only if the engine reports a good check. A response enable accompanies that pulse only when the frame was not a broadcast.

Top module: `rtu_frame_delim`

## Requirements
- R1: After reset all outputs are low.
- R2: The gap limit is L = floor(7*(10+P+S)*CYC_PER_BIT/2) cycles, where P is parity_en_i and S is two_stop_i. A character taken L or fewer cycles after the previous one (strobe to strobe) stays in the same frame. Otherwise the frame closes on the L-th clock edge after the edge that took its last character, so the final byte appears L+1 cycles after that character is driven.
- R3: Every received byte is output exactly once and in order, one character late. It is emitted on the edge that takes the next character of the frame, or on the closing edge. byte_first_o marks only the first (address) byte, and byte_last_o marks only the final byte.
- R4: For an eligible frame, chk_valid_o pulses together with the final byte. chk_word_o holds the final byte in bits 15:8 and the byte before it in bits 7:0.
- R5: If a frame is addressed to station_addr_i and crc_ok_i is high while chk_valid_o is high, then frame_ok_o and resp_en_o pulse for one cycle in the next cycle.
- R6: A frame addressed to 0 (broadcast) gives a frame_ok_o pulse with resp_en_o low.
- R7: A frame whose address is neither station_addr_i nor 0 gives neither chk_valid_o nor frame_ok_o.
- R8: If rx_err_i is high with any character of a frame, that frame gives neither chk_valid_o nor frame_ok_o.
- R9: A frame of fewer than 4 bytes gives neither chk_valid_o nor frame_ok_o. A frame of exactly 4 bytes is eligible.
- R10: If crc_ok_i is low while chk_valid_o is high, no frame_ok_o pulse follows.
- R11: A character taken L+1 or more cycles after the previous one starts a new frame. That character is tagged first, and the previous frame is closed on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| parity_en_i | input | 1 | Characters carry a parity bit |
| two_stop_i | input | 1 | Characters carry two stop bits |
| station_addr_i | input | 8 | Local station address |
| rx_valid_i | input | 1 | One-cycle strobe: a character has been received |
| rx_data_i | input | 8 | Received character |
| rx_err_i | input | 1 | Parity or framing error on this character |
| crc_ok_i | input | 1 | Check engine verdict, sampled while chk_valid_o is high |
| byte_valid_o | output | 1 | Tagged byte output strobe |
| byte_data_o | output | 8 | Tagged byte |
| byte_first_o | output | 1 | Byte is the frame's address byte |
| byte_last_o | output | 1 | Byte is the frame's final byte |
| chk_valid_o | output | 1 | Eligible frame closed; check word valid |
| chk_word_o | output | 16 | Final two bytes, final byte high |
| frame_ok_o | output | 1 | Frame accepted pulse |
| resp_en_o | output | 1 | Response permitted (accepted, not broadcast) |

## Verification
The hardest situation to reach is the exact boundary of the silence timer. One extra cycle of spacing turns a single frame into two, and the limit moves with each parity and stop-bit setting. The bench runs all four settings. In each it sends frames whose characters are spaced exactly L cycles apart, then pairs spaced L+1 apart, and checks the closing cycle against the arithmetic limit. The address filter is covered by a sweep over all 256 address values.

// File: rtl/rtu_delim_pkg.sv
package rtu_delim_pkg;

  typedef struct packed {
    logic [7:0] data;
    logic       first;
    logic       last;
  } tag_byte_t;

  // 3.5 character times in clock cycles, rounded down
  function automatic int unsigned gap_cycles(int unsigned cpb, logic par, logic two);
    int unsigned bits;
    bits = 10 + int'(par) + int'(two);
    return (7 * bits * cpb) / 2;
  endfunction

endpackage

// File: rtl/rtu_gap_timer.sv
module rtu_gap_timer #(
  parameter int unsigned CYC_PER_BIT = 16,
  parameter int unsigned CNT_W       = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic parity_en_i,
  input  logic two_stop_i,
  input  logic rx_valid_i,
  input  logic active_i,
  output logic gap_hit_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit     = CNT_W'(rtu_delim_pkg::gap_cycles(CYC_PER_BIT, parity_en_i, two_stop_i));
  assign gap_hit_o = active_i && !rx_valid_i && (cnt_q == limit - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!active_i || rx_valid_i) begin
      cnt_q <= '0;
    end else if (!gap_hit_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/rtu_byte_tagger.sv
module rtu_byte_tagger
  import rtu_delim_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  input  logic        close_i,
  output logic        active_o,
  output logic [15:0] tail_word_o,
  output logic        out_valid_o,
  output tag_byte_t   out_byte_o
);

  // one byte held back until it is known whether it is the last
  logic       hold_vld_q;
  logic       hold_first_q;
  logic [7:0] hold_data_q;
  logic [7:0] prev_data_q;
  logic       out_valid_q;
  tag_byte_t  out_byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_vld_q   <= 1'b0;
      hold_first_q <= 1'b0;
      hold_data_q  <= '0;
      prev_data_q  <= '0;
    end else if (rx_valid_i) begin
      hold_vld_q   <= 1'b1;
      hold_first_q <= !hold_vld_q;
      hold_data_q  <= rx_data_i;
      prev_data_q  <= hold_data_q;
    end else if (close_i) begin
      hold_vld_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_byte_q  <= '0;
    end else begin
      out_valid_q <= (rx_valid_i && hold_vld_q) || close_i;
      if ((rx_valid_i && hold_vld_q) || close_i) begin
        out_byte_q.data  <= hold_data_q;
        out_byte_q.first <= hold_first_q;
        out_byte_q.last  <= close_i;
      end
    end
  end

  assign active_o    = hold_vld_q;
  assign tail_word_o = {hold_data_q, prev_data_q};
  assign out_valid_o = out_valid_q;
  assign out_byte_o  = out_byte_q;

endmodule

// File: rtl/rtu_frame_judge.sv
module rtu_frame_judge #(
  parameter int unsigned MIN_LEN = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  station_addr_i,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_err_i,
  input  logic        active_i,
  input  logic        close_i,
  input  logic [15:0] tail_word_i,
  input  logic        crc_ok_i,
  output logic        chk_valid_o,
  output logic [15:0] chk_word_o,
  output logic        frame_ok_o,
  output logic        resp_en_o
);

  localparam int unsigned LEN_W = $clog2(MIN_LEN + 1);

  logic [7:0]       addr_q;
  logic             err_q;
  logic [LEN_W-1:0] len_q;
  logic             eligible;
  logic             chk_valid_q;
  logic [15:0]      chk_word_q;
  logic             bcast_q;
  logic             ok_q;
  logic             resp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      err_q  <= 1'b0;
      len_q  <= '0;
    end else if (rx_valid_i && !active_i) begin
      addr_q <= rx_data_i;
      err_q  <= rx_err_i;
      len_q  <= LEN_W'(1);
    end else if (rx_valid_i) begin
      err_q  <= err_q | rx_err_i;
      if (len_q != LEN_W'(MIN_LEN)) len_q <= len_q + 1'b1;
    end
  end

  assign eligible = (len_q == LEN_W'(MIN_LEN)) && !err_q &&
                    ((addr_q == station_addr_i) || (addr_q == 8'h00));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_valid_q <= 1'b0;
      chk_word_q  <= '0;
      bcast_q     <= 1'b0;
      ok_q        <= 1'b0;
      resp_q      <= 1'b0;
    end else begin
      chk_valid_q <= close_i && eligible;
      if (close_i) begin
        chk_word_q <= tail_word_i;
        bcast_q    <= (addr_q == 8'h00);
      end
      ok_q   <= chk_valid_q && crc_ok_i;
      resp_q <= chk_valid_q && crc_ok_i && !bcast_q;
    end
  end

  assign chk_valid_o = chk_valid_q;
  assign chk_word_o  = chk_word_q;
  assign frame_ok_o  = ok_q;
  assign resp_en_o   = resp_q;

endmodule

// File: rtl/rtu_frame_delim.sv
module rtu_frame_delim
  import rtu_delim_pkg::*;
#(
  parameter int unsigned CYC_PER_BIT = 16,
  parameter int unsigned MIN_LEN     = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        parity_en_i,
  input  logic        two_stop_i,
  input  logic [7:0]  station_addr_i,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_err_i,
  input  logic        crc_ok_i,
  output logic        byte_valid_o,
  output logic [7:0]  byte_data_o,
  output logic        byte_first_o,
  output logic        byte_last_o,
  output logic        chk_valid_o,
  output logic [15:0] chk_word_o,
  output logic        frame_ok_o,
  output logic        resp_en_o
);

  localparam int unsigned MAX_GAP = (7 * 12 * CYC_PER_BIT) / 2;
  localparam int unsigned CNT_W   = $clog2(MAX_GAP + 1);

  logic        frame_active;
  logic        gap_hit;
  logic [15:0] tail_word;
  tag_byte_t   out_byte;

  rtu_gap_timer #(
    .CYC_PER_BIT(CYC_PER_BIT),
    .CNT_W      (CNT_W)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .parity_en_i(parity_en_i),
    .two_stop_i (two_stop_i),
    .rx_valid_i (rx_valid_i),
    .active_i   (frame_active),
    .gap_hit_o  (gap_hit)
  );

  rtu_byte_tagger u_tag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .close_i    (gap_hit),
    .active_o   (frame_active),
    .tail_word_o(tail_word),
    .out_valid_o(byte_valid_o),
    .out_byte_o (out_byte)
  );

  rtu_frame_judge #(
    .MIN_LEN(MIN_LEN)
  ) u_judge (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .station_addr_i(station_addr_i),
    .rx_valid_i    (rx_valid_i),
    .rx_data_i     (rx_data_i),
    .rx_err_i      (rx_err_i),
    .active_i      (frame_active),
    .close_i       (gap_hit),
    .tail_word_i   (tail_word),
    .crc_ok_i      (crc_ok_i),
    .chk_valid_o   (chk_valid_o),
    .chk_word_o    (chk_word_o),
    .frame_ok_o    (frame_ok_o),
    .resp_en_o     (resp_en_o)
  );

  assign byte_data_o  = out_byte.data;
  assign byte_first_o = out_byte.first;
  assign byte_last_o  = out_byte.last;

endmodule

// File: rtl/rtu_frame_delim_chk.sv
module rtu_frame_delim_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_valid_i,
  input logic crc_ok_i,
  input logic frame_active,
  input logic gap_hit,
  input logic byte_valid_o,
  input logic byte_last_o,
  input logic chk_valid_o,
  input logic frame_ok_o,
  input logic resp_en_o
);

  a_r2_close_emits_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_hit |=> byte_valid_o && byte_last_o);

  a_r11_char_opens_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && !frame_active |=> frame_active);

  a_r4_chk_with_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_o |-> byte_valid_o && byte_last_o);

  a_r5_ok_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_o && crc_ok_i |=> frame_ok_o);

  a_r10_no_ok_without_good_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(chk_valid_o && crc_ok_i) |=> !frame_ok_o);

  a_r6_resp_within_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_en_o |-> frame_ok_o);

endmodule

bind rtu_frame_delim rtu_frame_delim_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_valid_i  (rx_valid_i),
  .crc_ok_i    (crc_ok_i),
  .frame_active(frame_active),
  .gap_hit     (gap_hit),
  .byte_valid_o(byte_valid_o),
  .byte_last_o (byte_last_o),
  .chk_valid_o (chk_valid_o),
  .frame_ok_o  (frame_ok_o),
  .resp_en_o   (resp_en_o)
);

// File: tb/tb_rtu_frame_delim.sv
module tb_rtu_frame_delim;

  localparam int CLK_PERIOD = 10;
  localparam int CPB        = 4;
  localparam logic [7:0] STA = 8'h2A;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        parity_en_i = 1'b0;
  logic        two_stop_i = 1'b0;
  logic [7:0]  station_addr_i = STA;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        rx_err_i = 1'b0;
  logic        crc_ok_i = 1'b0;
  logic        byte_valid_o;
  logic [7:0]  byte_data_o;
  logic        byte_first_o;
  logic        byte_last_o;
  logic        chk_valid_o;
  logic [15:0] chk_word_o;
  logic        frame_ok_o;
  logic        resp_en_o;

  rtu_frame_delim #(.CYC_PER_BIT(CPB), .MIN_LEN(4)) dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int n_checks = 0;
  int n_fail   = 0;

  // monitor log
  logic [7:0] mon_data [16];
  logic       mon_first[16];
  logic       mon_last [16];
  int         mon_n, n_chk, n_ok, n_resp, last_cyc;
  logic [15:0] mon_word;

  // stimulus buffer
  logic [7:0] tx_buf[8];
  int         drive_cyc;

  always @(posedge clk_i) begin
    #1;
    if (byte_valid_o && mon_n < 16) begin
      mon_data[mon_n]  = byte_data_o;
      mon_first[mon_n] = byte_first_o;
      mon_last[mon_n]  = byte_last_o;
      if (byte_last_o) last_cyc = cyc;
      mon_n = mon_n + 1;
    end
    if (chk_valid_o) begin n_chk = n_chk + 1; mon_word = chk_word_o; end
    if (frame_ok_o) n_ok = n_ok + 1;
    if (resp_en_o) n_resp = n_resp + 1;
  end

  task automatic check(input bit cond, input string req, input int act, input int exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int limit_of(input logic p, input logic s);
    return (7 * (10 + int'(p) + int'(s)) * CPB) / 2;
  endfunction

  task automatic clear_log();
    mon_n = 0; n_chk = 0; n_ok = 0; n_resp = 0; last_cyc = -1; mon_word = '0;
  endtask

  // send len bytes of tx_buf spaced sp cycles; err_idx marks an errored char (-1: none)
  task automatic send(input int len, input int sp, input int err_idx);
    for (int i = 0; i < len; i++) begin
      rx_valid_i = 1'b1;
      rx_data_i  = tx_buf[i];
      rx_err_i   = (i == err_idx);
      drive_cyc  = cyc;
      @(negedge clk_i);
      rx_valid_i = 1'b0;
      rx_err_i   = 1'b0;
      repeat (sp - 1) @(negedge clk_i);
    end
    repeat (limit_of(parity_en_i, two_stop_i) + 4) @(negedge clk_i);
  endtask

  // full frame with all stream checks
  task automatic frame(input int len, input int sp, input int err_idx, input bit crc);
    bit elig, ok, rsp;
    int lim;
    lim  = limit_of(parity_en_i, two_stop_i);
    clear_log();
    crc_ok_i = crc;
    send(len, sp, err_idx);
    elig = (len >= 4) && (err_idx < 0) && (tx_buf[0] == STA || tx_buf[0] == 8'h00);
    ok   = elig && crc;
    rsp  = ok && (tx_buf[0] != 8'h00);
    check(mon_n == len, "R3 byte count", mon_n, len);
    for (int i = 0; i < len && i < mon_n; i++) begin
      check(mon_data[i] == tx_buf[i], "R3 byte data", mon_data[i], tx_buf[i]);
      check(mon_first[i] == (i == 0), "R3 first flag", mon_first[i], i == 0);
      check(mon_last[i] == (i == len - 1), "R3 last flag", mon_last[i], i == len - 1);
    end
    check(last_cyc == drive_cyc + lim + 1, "R2 close cycle", last_cyc, drive_cyc + lim + 1);
    check(n_chk == int'(elig), "R4 R7 R8 R9 chk strobe", n_chk, elig);
    if (elig && len >= 2)
      check(mon_word == {tx_buf[len-1], tx_buf[len-2]}, "R4 chk word", mon_word,
            {tx_buf[len-1], tx_buf[len-2]});
    check(n_ok == int'(ok), "R5 R6 R10 frame ok", n_ok, ok);
    check(n_resp == int'(rsp), "R5 R6 resp en", n_resp, rsp);
    crc_ok_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    clear_log();
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(!byte_valid_o && !chk_valid_o && !frame_ok_o && !resp_en_o && !byte_first_o
          && !byte_last_o, "R1 reset outputs", byte_valid_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    for (int cfg = 0; cfg < 4; cfg++) begin
      int lim;
      parity_en_i = cfg[0];
      two_stop_i  = cfg[1];
      lim = limit_of(parity_en_i, two_stop_i);
      // R2: spacing exactly the limit keeps one frame
      tx_buf[0] = STA; tx_buf[1] = 8'h03; tx_buf[2] = 8'hA5; tx_buf[3] = 8'h5A; tx_buf[4] = 8'hC3;
      frame(5, lim, -1, 1'b1);
      // R11: spacing limit+1 splits into single-byte frames
      clear_log();
      tx_buf[0] = STA; tx_buf[1] = 8'h77;
      send(2, lim + 1, -1);
      check(mon_n == 2, "R11 split count", mon_n, 2);
      check(mon_first[0] && mon_last[0], "R11 first frame closed alone", mon_first[0], 1);
      check(mon_first[1] && mon_last[1] && mon_data[1] == 8'h77, "R11 new frame first",
            mon_first[1], 1);
      check(n_chk == 0 && n_ok == 0, "R11 R9 no accept of split", n_ok, 0);
    end

    parity_en_i = 1'b0; two_stop_i = 1'b0;
    tx_buf[0] = STA; tx_buf[1] = 8'h06; tx_buf[2] = 8'h12; tx_buf[3] = 8'h34;
    tx_buf[4] = 8'h56; tx_buf[5] = 8'h78;
    frame(4, 3, -1, 1'b1);   // R9 exactly four
    frame(3, 3, -1, 1'b1);   // R9 short
    frame(2, 5, -1, 1'b1);   // R9 short
    frame(6, 3, -1, 1'b0);   // R10 bad check
    frame(6, 3, 0, 1'b1);    // R8 error on address
    frame(6, 3, 5, 1'b1);    // R8 error on last
    frame(6, 3, 2, 1'b1);    // R8 error mid
    tx_buf[0] = 8'h00;
    frame(4, 2, -1, 1'b1);   // R6 broadcast
    tx_buf[0] = 8'h2B;
    frame(5, 2, -1, 1'b1);   // R7 foreign

    // address sweep: R5 R6 R7
    for (int a = 0; a < 256; a++) begin
      bit exp_ok, exp_rsp;
      clear_log();
      crc_ok_i = 1'b1;
      tx_buf[0] = 8'(a); tx_buf[1] = 8'h03; tx_buf[2] = 8'(a ^ 8'h5C); tx_buf[3] = 8'h22;
      send(4, 4, -1);
      exp_ok  = (8'(a) == STA) || (a == 0);
      exp_rsp = (8'(a) == STA);
      check(n_ok == int'(exp_ok), "R7 sweep frame ok", n_ok, exp_ok);
      check(n_resp == int'(exp_rsp), "R6 sweep resp en", n_resp, exp_rsp);
      crc_ok_i = 1'b0;
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule